// File: doc/BRIEF.md
# Dual Halfword Multiply-Subtract-Accumulate Unit

This DSP execution datapath takes two 32-bit operands and reads each one as a pair of signed 16-bit halfwords. It forms two signed 16x16 products. The product of the upper pair is subtracted from the product of the lower pair, and an accumulate value is added to the difference. A swap control exchanges the two halfwords of the second operand before the multiplies, which turns the straight pairing into a cross pairing.

Two accumulate widths are supported. In short mode the accumulator is a signed 32-bit word. The result wraps to 32 bits, and a sticky flag records any signed overflow of the final addition. In long mode the accumulator is a 64-bit value given as a high word and a low word. The product difference is sign-extended and added, and the 64-bit sum is returned as two words. The caller presents one operation per `valid_i` strobe. The result registers update on the next clock edge, and `valid_o` is high in that cycle.

Top module: `dmsa_unit`

## Requirements
- R1: Bits 15:0 of each operand are the bottom signed halfword and bits 31:16 are the top signed halfword. With `swap_i`=0 the products are a.bottom*b.bottom (lower pair) and a.top*b.top (upper pair).
- R2: With `swap_i`=1 the lower pair is a.bottom*b.top and the upper pair is a.top*b.bottom.
- R3: The product difference (lower minus upper) is exact and fits in 32 signed bits for every input, including the -32768 operand corners.
- R4: In short mode (`long_i`=0) the accumulator is `acc_lo_i`, read as signed. `res_lo_o` is the sum modulo 2^32, with no saturation, and `res_hi_o` is zero.
- R5: A short-mode operation whose signed 32-bit addition overflows sets `ovf_o`, visible in the same cycle as its result.
- R6: `ovf_o` is sticky: no non-overflowing operation clears it. `clr_ovf_i`=1 clears it at the next edge, unless an overflowing short operation is accepted in the same cycle, in which case the flag stays set.
- R7: In long mode (`long_i`=1) the accumulator is {`acc_hi_i`,`acc_lo_i`}. The difference is sign-extended to 64 bits, and the sum modulo 2^64 is returned as {`res_hi_o`,`res_lo_o`}.
- R8: Long-mode operations never change `ovf_o`.
- R9: `valid_o` is high exactly in the cycle after a cycle with `valid_i`=1. The result outputs hold their value while no operation is accepted.
- R10: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| swap_i | input | 1 | Exchange the halfwords of op_b_i |
| long_i | input | 1 | 1: 64-bit accumulate, 0: 32-bit accumulate |
| clr_ovf_i | input | 1 | Clear the sticky overflow flag |
| op_a_i | input | 32 | First operand, two signed halfwords |
| op_b_i | input | 32 | Second operand, two signed halfwords |
| acc_lo_i | input | 32 | Short accumulator, or low word of the long accumulator |
| acc_hi_i | input | 32 | High word of the long accumulator |
| res_lo_o | output | 32 | Short result, or low word of the long result |
| res_hi_o | output | 32 | High word of the long result; zero in short mode |
| valid_o | output | 1 | Result valid |
| ovf_o | output | 1 | Sticky short-mode overflow flag |

## Verification
The same operand pair is applied with swap off and then with swap on. Unequal halfwords make the straight and crossed pairings give different sums, so a wrong pairing shows up at once. Operands with negative halfwords and the -32768 corners separate signed from unsigned multiplication and test whether the difference fits in 32 bits. Short accumulates near the signed limits, and long accumulates that carry across the word boundary or wrap past 2^64, separate the two add paths and their sign extension. Sequences of overflow, a quiet operation, a clear, and a clear on the same cycle as an overflow test the flag's persistence and priority. A long random run is compared against a behavioural model on every clock.

// File: rtl/dmsa_pkg.sv
package dmsa_pkg;
  localparam int unsigned HALF_W_DEF = 16;
  typedef enum logic {ACC_SHORT = 1'b0, ACC_LONG = 1'b1} acc_mode_e;
endpackage

// File: rtl/dmsa_opsel.sv
module dmsa_opsel #(
  parameter int unsigned HALF_W = dmsa_pkg::HALF_W_DEF,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0]        a_i,
  input  logic [WORD_W-1:0]        b_i,
  input  logic                     swap_i,
  output logic signed [HALF_W-1:0] lo_a_o,
  output logic signed [HALF_W-1:0] lo_b_o,
  output logic signed [HALF_W-1:0] hi_a_o,
  output logic signed [HALF_W-1:0] hi_b_o
);
  logic [HALF_W-1:0] b_bot, b_top;

  assign b_bot  = b_i[HALF_W-1:0];
  assign b_top  = b_i[WORD_W-1:HALF_W];
  assign lo_a_o = a_i[HALF_W-1:0];
  assign hi_a_o = a_i[WORD_W-1:HALF_W];

  always_comb begin
    if (swap_i) begin
      lo_b_o = b_top;
      hi_b_o = b_bot;
    end else begin
      lo_b_o = b_bot;
      hi_b_o = b_top;
    end
  end
endmodule

// File: rtl/dmsa_muldiff.sv
module dmsa_muldiff #(
  parameter int unsigned HALF_W = dmsa_pkg::HALF_W_DEF,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic signed [HALF_W-1:0] lo_a_i,
  input  logic signed [HALF_W-1:0] lo_b_i,
  input  logic signed [HALF_W-1:0] hi_a_i,
  input  logic signed [HALF_W-1:0] hi_b_i,
  output logic signed [WORD_W-1:0] diff_o
);
  logic signed [HALF_W-1:0] mul_x [2];
  logic signed [HALF_W-1:0] mul_y [2];
  logic signed [PROD_W-1:0] prod  [2];
  logic signed [WORD_W:0]   diff_wide;

  assign mul_x[0] = lo_a_i;
  assign mul_y[0] = lo_b_i;
  assign mul_x[1] = hi_a_i;
  assign mul_y[1] = hi_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_mul
    assign prod[g] = mul_x[g] * mul_y[g];
  end

  // one guard bit; the final value always fits WORD_W
  assign diff_wide = {prod[0][PROD_W-1], prod[0]} - {prod[1][PROD_W-1], prod[1]};
  assign diff_o    = diff_wide[WORD_W-1:0];

  always_comb begin
    if (!$isunknown(diff_wide)) begin
      assert_diff_fits_R3: assert (diff_wide[WORD_W] == diff_wide[WORD_W-1])
        else $error("product difference exceeds word width");
    end
  end
endmodule

// File: rtl/dmsa_acc.sv
module dmsa_acc #(
  parameter int unsigned HALF_W = dmsa_pkg::HALF_W_DEF,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned LONG_W = 2 * WORD_W
) (
  input  logic signed [WORD_W-1:0] diff_i,
  input  dmsa_pkg::acc_mode_e      mode_i,
  input  logic [WORD_W-1:0]        acc_lo_i,
  input  logic [WORD_W-1:0]        acc_hi_i,
  output logic [WORD_W-1:0]        sum_lo_o,
  output logic [WORD_W-1:0]        sum_hi_o,
  output logic                     ovf_o
);
  logic [WORD_W:0]   short_sum;
  logic [LONG_W-1:0] long_sum;

  assign short_sum = {diff_i[WORD_W-1], diff_i} + {acc_lo_i[WORD_W-1], acc_lo_i};
  assign long_sum  = {{WORD_W{diff_i[WORD_W-1]}}, diff_i} + {acc_hi_i, acc_lo_i};

  always_comb begin
    if (mode_i == dmsa_pkg::ACC_LONG) begin
      sum_lo_o = long_sum[WORD_W-1:0];
      sum_hi_o = long_sum[LONG_W-1:WORD_W];
      ovf_o    = 1'b0;
    end else begin
      sum_lo_o = short_sum[WORD_W-1:0];
      sum_hi_o = '0;
      ovf_o    = short_sum[WORD_W] ^ short_sum[WORD_W-1];
    end
  end
endmodule

// File: rtl/dmsa_unit.sv
module dmsa_unit #(
  parameter int unsigned HALF_W = dmsa_pkg::HALF_W_DEF,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              swap_i,
  input  logic              long_i,
  input  logic              clr_ovf_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic [WORD_W-1:0] acc_lo_i,
  input  logic [WORD_W-1:0] acc_hi_i,
  output logic [WORD_W-1:0] res_lo_o,
  output logic [WORD_W-1:0] res_hi_o,
  output logic              valid_o,
  output logic              ovf_o
);
  logic signed [HALF_W-1:0] lo_a, lo_b, hi_a, hi_b;
  logic signed [WORD_W-1:0] diff;
  logic [WORD_W-1:0]        sum_lo, sum_hi;
  logic                     add_ovf;
  dmsa_pkg::acc_mode_e      mode;

  assign mode = long_i ? dmsa_pkg::ACC_LONG : dmsa_pkg::ACC_SHORT;

  dmsa_opsel #(.HALF_W(HALF_W)) u_opsel (
    .a_i(op_a_i), .b_i(op_b_i), .swap_i(swap_i),
    .lo_a_o(lo_a), .lo_b_o(lo_b), .hi_a_o(hi_a), .hi_b_o(hi_b)
  );

  dmsa_muldiff #(.HALF_W(HALF_W)) u_muldiff (
    .lo_a_i(lo_a), .lo_b_i(lo_b), .hi_a_i(hi_a), .hi_b_i(hi_b), .diff_o(diff)
  );

  dmsa_acc #(.HALF_W(HALF_W)) u_acc (
    .diff_i(diff), .mode_i(mode), .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i),
    .sum_lo_o(sum_lo), .sum_hi_o(sum_hi), .ovf_o(add_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_lo_o <= '0;
      res_hi_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_lo_o <= sum_lo;
        res_hi_o <= sum_hi;
      end
    end
  end

  // set beats clear so a fresh overflow is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ovf_o <= 1'b0;
    else if (valid_i && !long_i && add_ovf)       ovf_o <= 1'b1;
    else if (clr_ovf_i)                           ovf_o <= 1'b0;
  end

  assert_valid_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_lo_o) && $stable(res_hi_o)));
  assert_short_hi_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !long_i) |=> (res_hi_o == '0));
  assert_ovf_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !long_i && add_ovf) |=> ovf_o);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_ovf_i) |=> ovf_o);
  assert_long_keeps_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(valid_i && !long_i) && !clr_ovf_i) |=> $stable(ovf_o));
endmodule

// File: tb/dmsa_unit_tb.sv
module dmsa_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, swap = 1'b0, lng = 1'b0, clr = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc_lo = '0, acc_hi = '0;
  logic [31:0] res_lo, res_hi;
  logic        valid_o, ovf;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  logic        m_valid = 1'b0, m_ovf = 1'b0;
  logic [31:0] m_lo = '0, m_hi = '0;

  always #4 clk = ~clk;

  dmsa_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .swap_i(swap), .long_i(lng),
    .clr_ovf_i(clr), .op_a_i(op_a), .op_b_i(op_b), .acc_lo_i(acc_lo),
    .acc_hi_i(acc_hi), .res_lo_o(res_lo), .res_hi_o(res_hi),
    .valid_o(valid_o), .ovf_o(ovf)
  );

  function automatic longint ref_diff(logic [31:0] a, logic [31:0] b, logic sw);
    longint ab, at, bb, bt;
    ab = longint'($signed(a[15:0]));
    at = longint'($signed(a[31:16]));
    bb = longint'($signed(b[15:0]));
    bt = longint'($signed(b[31:16]));
    return sw ? (ab * bt - at * bb) : (ab * bb - at * bt);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "valid_o", {31'd0, valid_o}, {31'd0, m_valid});
    chk(tag, "res_lo_o", res_lo, m_lo);
    chk(tag, "res_hi_o", res_hi, m_hi);
    chk(tag, "ovf_o", {31'd0, ovf}, {31'd0, m_ovf});
  endtask

  // drive at negedge, compare at the next negedge
  task automatic step(string tag, logic v, logic sw, logic l, logic c,
                      logic [31:0] a, logic [31:0] b, logic [31:0] lo, logic [31:0] hi);
    longint d, s, acc64;
    logic of;
    valid = v; swap = sw; lng = l; clr = c;
    op_a = a; op_b = b; acc_lo = lo; acc_hi = hi;
    of = 1'b0;
    m_valid = v;
    if (v) begin
      d = ref_diff(a, b, sw);
      if (l) begin
        acc64 = longint'({hi, lo});
        s = acc64 + d;
        m_lo = s[31:0];
        m_hi = s[63:32];
      end else begin
        s = d + longint'($signed(lo));
        of = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        m_lo = s[31:0];
        m_hi = '0;
      end
    end
    if (v && !l && of) m_ovf = 1'b1;
    else if (c)        m_ovf = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    compare("R10");                      // R10 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10");

    // R1 straight pairing: 5*2 - 3*7 + 100 = 89
    step("R1", 1, 0, 0, 0, 32'h0003_0005, 32'h0007_0002, 32'd100, 32'h0);
    // R2 cross pairing: 5*7 - 3*2 + 100 = 129
    step("R2", 1, 1, 0, 0, 32'h0003_0005, 32'h0007_0002, 32'd100, 32'h0);
    // R1 signed halves
    step("R1", 1, 0, 0, 0, 32'hFFFF_0001, 32'h0002_FFFD, 32'h0, 32'h0);
    // R3 corners
    step("R3", 1, 0, 0, 0, 32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0);
    step("R3", 1, 0, 0, 0, 32'h8000_8000, 32'h7FFF_8000, 32'h0, 32'h0);
    step("R3", 1, 1, 0, 0, 32'h7FFF_8000, 32'h7FFF_8000, 32'h0, 32'h0);
    // R4 wrap without saturation, R5 flag set on positive overflow
    step("R5", 1, 0, 0, 0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_0000, 32'hFFFF_FFFF);
    // R6 quiet op keeps flag
    step("R6", 1, 0, 0, 0, 32'h0000_0001, 32'h0000_0001, 32'h1, 32'h0);
    // R9 idle keeps results
    step("R9", 0, 0, 0, 0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h5, 32'h6);
    step("R9", 0, 1, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7, 32'h8);
    // R6 clear
    step("R6", 0, 0, 0, 1, 32'h0, 32'h0, 32'h0, 32'h0);
    // R4 negative overflow wraps, R5 sets
    step("R4", 1, 0, 0, 0, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 32'h0);
    // R6 set wins over clear in same cycle
    step("R6", 1, 0, 0, 1, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 32'h0);
    // R8 long op with flag set
    step("R8", 1, 0, 1, 0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    step("R6", 0, 0, 0, 1, 32'h0, 32'h0, 32'h0, 32'h0);
    // R7 carry across the word boundary
    step("R7", 1, 0, 1, 0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0);
    // R7 negative difference sign-extends
    step("R7", 1, 0, 1, 0, 32'h0000_0001, 32'h0000_FFFF, 32'h0, 32'h0);
    // R7 wrap past 2^64, R8 flag stays clear
    step("R8", 1, 1, 1, 0, 32'h0000_0001, 32'h0001_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R9 back-to-back then gap
    step("R9", 1, 0, 0, 0, 32'h0002_0003, 32'h0004_0005, 32'h0, 32'h0);
    step("R9", 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0);

    for (int i = 0; i < 600; i++) begin
      step("R3", ($urandom % 4) != 0, $urandom % 2, $urandom % 2, ($urandom % 8) == 0,
           $urandom, $urandom, $urandom, $urandom);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule